// File: doc/BRIEF.md
# Translation Cache with Masked Invalidation

This block keeps recently used page translations in a small fully associative cache placed in front of a two-level page-table walker. It also keeps a second, smaller cache of first-level directory entries that the walker consumes. A client presents a 32-bit virtual address. On a hit the block returns the physical address one cycle later. On a miss it raises a walk request toward the walker, passes along any cached directory entry for the 1 MB region, and waits for the walker's answer. It then caches the result, unless the walk faulted.

Software maintains both caches through a small register port with single-cycle writes and combinational reads. Three operations are available: a flush of whole caches, removal of translations that match an address under a programmable mask, and removal of the directory entry for one 1 MB region. Each operation is started by setting a go bit. The go bit reads back as 1 until the hardware has swept every entry, and then it drops to 0. While any operation is pending, lookups are held off, so a translation that is about to be removed is never returned.

Top module: `xlat_cache`

## Requirements
- R1: After reset, both caches hold no valid entries, every go bit reads 0, the mask register reads 0xFFFFF000, and the first lookup raises a walk request.
- R2: A lookup whose page number (address bits 31:12) is cached is accepted while `lkReady` is 1. `rspValid` rises in the next cycle with `rspPa` = {cached page, lookup bits 11:0}, `rspFault` = 0, and no walk request is raised.
- R3: A lookup that misses raises `walkReq` with `walkVa` equal to the lookup address. `walkReq` stays high until `walkDone`. `rspValid` follows one cycle after `walkDone` with {`walkPpn`, offset}, and a later lookup of the same page hits.
- R4: A walk that ends with `walkFault` = 1 returns `rspFault` = 1 and is not cached, so the same page walks again on its next lookup.
- R5: Fills replace translation entries in round-robin order. After TLB_ENTRIES+1 distinct fills, the first page filled is gone and the others remain.
- R6: Register 0x0C bit 0 starts a masked invalidation. It removes every translation whose page address p satisfies ((p ^ addr@0x04) & mask@0x08) == 0, keeps all other translations, and reads 1 until it completes.
- R7: In register 0x00, bit 16 flushes the translation cache, bit 17 flushes the directory cache, and bits 5:0 are per-client flush bits. Each written bit reads back as 1 until the flush completes and then reads 0.
- R8: On a walk request, `walkDirHit`/`walkDirEntry` present the cached directory entry whose tag equals lookup bits 31:20. After a successful walk with `walkDirFill` = 1 and no cached entry for that region, `walkDirData` is stored in round-robin order.
- R9: Register 0x14 bit 0 removes the cached directory entry whose tag equals bits 31:20 of register 0x10, and reads 1 until done. Entries for other regions remain.
- R10: While any go or flush bit is pending, `lkReady` is 0 and a presented lookup waits. A lookup that follows an invalidation sees its effect.
- R11: Writing 0 to a go bit starts nothing and changes no cache content. Every started operation clears its bits within max(TLB_ENTRIES, DIR_ENTRIES)+2 cycles after the write, as long as no walk is outstanding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 1 | Register access strobe |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 8 | Byte offset of the register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data (combinational) |
| lkValid | input | 1 | Lookup presented |
| lkVa | input | 32 | Lookup virtual address |
| lkReady | output | 1 | Lookup accepted this cycle when high with lkValid |
| rspValid | output | 1 | One-cycle response pulse |
| rspPa | output | 32 | Translated physical address |
| rspFault | output | 1 | Response is a fault |
| walkReq | output | 1 | Walk requested for walkVa |
| walkVa | output | 32 | Address to walk |
| walkDirHit | output | 1 | Cached directory entry available |
| walkDirEntry | output | 32 | Cached directory entry |
| walkDone | input | 1 | Walker finished |
| walkFault | input | 1 | Walk found no valid mapping |
| walkPpn | input | 20 | Physical page number from the walk |
| walkDirFill | input | 1 | walkDirData holds a valid directory entry |
| walkDirData | input | 32 | Directory entry fetched by the walker |

## Verification
The bench builds the block with eight translation entries and four directory entries. With these sizes, nine fills are enough to wrap the round-robin pointer, and five regions are enough to evict a directory entry. An eight-cycle sweep also keeps the completion bound tight enough to test every time. Random lookups draw from three regions of twenty pages, so hits, evictions and region-wide invalidations all recur often. The random maintenance traffic mixes exact-page masks, 16 KB masks and whole-region masks.

// File: rtl/xlat_cache_pkg.sv
package xlat_cache_pkg;
  localparam int VA_W         = 32;
  localparam int PAGE_SHIFT   = 12;
  localparam int REGION_SHIFT = 20;
  localparam int VPN_W        = VA_W - PAGE_SHIFT;
  localparam int TAG_W        = VA_W - REGION_SHIFT;
  localparam int MASTER_N     = 6;
  localparam int FL_MAIN_BIT  = 16;
  localparam int FL_WALK_BIT  = 17;

  // register word indices (byte offset / 4)
  localparam logic [2:0] RIDX_FLUSH  = 3'd0;
  localparam logic [2:0] RIDX_INVA   = 3'd1;
  localparam logic [2:0] RIDX_INVM   = 3'd2;
  localparam logic [2:0] RIDX_INVGO  = 3'd3;
  localparam logic [2:0] RIDX_WINVA  = 3'd4;
  localparam logic [2:0] RIDX_WINVGO = 3'd5;

  typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_SWEEP} ctrlState_t;

  typedef struct packed {
    logic captureVa;
    logic fillMain;
    logic fillWalk;
    logic sweepEn;
    logic clrMainAll;
    logic clrWalkAll;
    logic invMain;
    logic invWalk;
  } dpStrobe_t;
endpackage

// File: rtl/xlat_cache_dp.sv
module xlat_cache_dp
  import xlat_cache_pkg::*;
#(
  parameter int TLB_ENTRIES = 8,
  parameter int DIR_ENTRIES = 4,
  parameter int SWW         = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [SWW-1:0]   sweepIdx,
  input  logic [VA_W-1:0]  lkVa,
  input  logic [VPN_W-1:0] walkPpn,
  input  logic [VA_W-1:0]  walkDirData,
  input  logic [VA_W-1:0]  invAddr,
  input  logic [VA_W-1:0]  invMask,
  input  logic [TAG_W-1:0] walkInvTag,
  output logic             hitAny,
  output logic [VPN_W-1:0] hitPpn,
  output logic             dirHit,
  output logic [VA_W-1:0]  dirEntry,
  output logic [VA_W-1:0]  curVa
);
  localparam int TLB_IW = (TLB_ENTRIES > 1) ? $clog2(TLB_ENTRIES) : 1;
  localparam int DIR_IW = (DIR_ENTRIES > 1) ? $clog2(DIR_ENTRIES) : 1;

  logic [TLB_ENTRIES-1:0] tVld, tHitVec, tInvVec, tKill;
  logic [VPN_W-1:0]       tVpn [TLB_ENTRIES];
  logic [VPN_W-1:0]       tPpn [TLB_ENTRIES];
  logic [TLB_IW-1:0]      tRr;

  logic [DIR_ENTRIES-1:0] dVld, dHitVec, dKill;
  logic [TAG_W-1:0]       dTag [DIR_ENTRIES];
  logic [VA_W-1:0]        dData [DIR_ENTRIES];
  logic [DIR_IW-1:0]      dRr;

  // per-entry compare logic for the translation cache
  for (genvar gi = 0; gi < TLB_ENTRIES; gi++) begin : g_tlbCmp
    assign tHitVec[gi] = tVld[gi] && (tVpn[gi] == lkVa[VA_W-1:PAGE_SHIFT]);
    assign tInvVec[gi] = ((({tVpn[gi], {PAGE_SHIFT{1'b0}}}) ^ invAddr) & invMask) == '0;
    assign tKill[gi]   = strobe.sweepEn && (sweepIdx == SWW'(gi)) &&
                         (strobe.clrMainAll || (strobe.invMain && tInvVec[gi]));
  end

  // per-entry compare logic for the directory cache
  for (genvar gj = 0; gj < DIR_ENTRIES; gj++) begin : g_dirCmp
    assign dHitVec[gj] = dVld[gj] && (dTag[gj] == curVa[VA_W-1:REGION_SHIFT]);
    assign dKill[gj]   = strobe.sweepEn && (sweepIdx == SWW'(gj)) &&
                         (strobe.clrWalkAll || (strobe.invWalk && dTag[gj] == walkInvTag));
  end

  always_comb begin
    hitPpn = '0;
    for (int i = 0; i < TLB_ENTRIES; i++)
      if (tHitVec[i]) hitPpn = hitPpn | tPpn[i];
  end
  assign hitAny = |tHitVec;

  always_comb begin
    dirEntry = '0;
    for (int j = 0; j < DIR_ENTRIES; j++)
      if (dHitVec[j]) dirEntry = dirEntry | dData[j];
  end
  assign dirHit = |dHitVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curVa <= '0;
    else if (strobe.captureVa) curVa <= lkVa;
  end

  // translation cache valid bits and replacement pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tVld <= '0;
      tRr  <= '0;
    end else begin
      for (int i = 0; i < TLB_ENTRIES; i++)
        if (tKill[i]) tVld[i] <= 1'b0;
      if (strobe.fillMain) begin
        tVld[tRr] <= 1'b1;
        tRr <= (tRr == TLB_IW'(TLB_ENTRIES - 1)) ? '0 : tRr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fillMain) begin
      tVpn[tRr] <= curVa[VA_W-1:PAGE_SHIFT];
      tPpn[tRr] <= walkPpn;
    end
  end

  // directory cache valid bits and replacement pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dVld <= '0;
      dRr  <= '0;
    end else begin
      for (int j = 0; j < DIR_ENTRIES; j++)
        if (dKill[j]) dVld[j] <= 1'b0;
      if (strobe.fillWalk && !dirHit) begin
        dVld[dRr] <= 1'b1;
        dRr <= (dRr == DIR_IW'(DIR_ENTRIES - 1)) ? '0 : dRr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fillWalk && !dirHit) begin
      dTag[dRr]  <= curVa[VA_W-1:REGION_SHIFT];
      dData[dRr] <= walkDirData;
    end
  end
endmodule

// File: rtl/xlat_cache_ctrl.sv
module xlat_cache_ctrl
  import xlat_cache_pkg::*;
#(
  parameter int SWEEP_LEN = 8,
  parameter int SWW       = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regSel,
  input  logic             regWrite,
  input  logic [7:0]       regAddr,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  input  logic             lkValid,
  input  logic [VA_W-1:0]  lkVa,
  output logic             lkReady,
  input  logic             hitAny,
  input  logic [VPN_W-1:0] hitPpn,
  input  logic [VA_W-1:0]  curVa,
  input  logic             walkDone,
  input  logic             walkFault,
  input  logic [VPN_W-1:0] walkPpn,
  input  logic             walkDirFill,
  output logic             walkReq,
  output logic             rspValid,
  output logic [VA_W-1:0]  rspPa,
  output logic             rspFault,
  output dpStrobe_t        strobe,
  output logic [SWW-1:0]   sweepIdx,
  output logic [VA_W-1:0]  invAddr,
  output logic [VA_W-1:0]  invMask,
  output logic [TAG_W-1:0] walkInvTag,
  output logic             maintPending
);
  localparam int FL_W = MASTER_N + 2;

  ctrlState_t      state;
  logic [FL_W-1:0] flushPend, snapFlush, flushSet, flushEndClr;
  logic            invGo, walkGo, snapInv, snapWalk;
  logic            regOk, wrEn, sweepEnd;
  logic [2:0]      regIdx;

  assign regIdx   = regAddr[4:2];
  assign regOk    = (regAddr[7:5] == 3'd0) && (regAddr[1:0] == 2'd0);
  assign wrEn     = regSel && regWrite && regOk;
  assign sweepEnd = (state == ST_SWEEP) && (sweepIdx == SWW'(SWEEP_LEN - 1));

  assign flushSet    = (wrEn && regIdx == RIDX_FLUSH) ?
                       {regWdata[FL_WALK_BIT], regWdata[FL_MAIN_BIT], regWdata[MASTER_N-1:0]} : '0;
  assign flushEndClr = sweepEnd ? snapFlush : '0;

  assign maintPending = (|flushPend) || invGo || walkGo;
  assign lkReady      = (state == ST_IDLE) && !maintPending;
  assign walkReq      = (state == ST_WALK);

  always_comb begin
    strobe            = '0;
    strobe.captureVa  = lkReady && lkValid;
    strobe.fillMain   = walkReq && walkDone && !walkFault;
    strobe.fillWalk   = walkReq && walkDone && !walkFault && walkDirFill;
    strobe.sweepEn    = (state == ST_SWEEP);
    strobe.clrMainAll = snapFlush[MASTER_N];
    strobe.clrWalkAll = snapFlush[MASTER_N+1];
    strobe.invMain    = snapInv;
    strobe.invWalk    = snapWalk;
  end

  always_comb begin
    regRdata = '0;
    if (regOk) begin
      case (regIdx)
        RIDX_FLUSH:  regRdata = {14'd0, flushPend[MASTER_N+1], flushPend[MASTER_N],
                                 10'd0, flushPend[MASTER_N-1:0]};
        RIDX_INVA:   regRdata = invAddr;
        RIDX_INVM:   regRdata = invMask;
        RIDX_INVGO:  regRdata = {31'd0, invGo};
        RIDX_WINVA:  regRdata = {walkInvTag, {REGION_SHIFT{1'b0}}};
        RIDX_WINVGO: regRdata = {31'd0, walkGo};
        default:     regRdata = '0;
      endcase
    end
  end

  // software-visible registers; completion clears only the bits a sweep took
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flushPend  <= '0;
      invGo      <= 1'b0;
      walkGo     <= 1'b0;
      invAddr    <= '0;
      invMask    <= 32'hFFFF_F000;
      walkInvTag <= '0;
    end else begin
      flushPend <= (flushPend & ~flushEndClr) | flushSet;
      invGo  <= (invGo  && !(sweepEnd && snapInv)) ||
                (wrEn && regIdx == RIDX_INVGO && regWdata[0]);
      walkGo <= (walkGo && !(sweepEnd && snapWalk)) ||
                (wrEn && regIdx == RIDX_WINVGO && regWdata[0]);
      if (wrEn && regIdx == RIDX_INVA)  invAddr    <= regWdata;
      if (wrEn && regIdx == RIDX_INVM)  invMask    <= regWdata;
      if (wrEn && regIdx == RIDX_WINVA) walkInvTag <= regWdata[VA_W-1:REGION_SHIFT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      sweepIdx  <= '0;
      snapFlush <= '0;
      snapInv   <= 1'b0;
      snapWalk  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (maintPending) begin
            state     <= ST_SWEEP;
            sweepIdx  <= '0;
            snapFlush <= flushPend;
            snapInv   <= invGo;
            snapWalk  <= walkGo;
          end else if (lkValid && !hitAny) begin
            state <= ST_WALK;
          end
        end
        ST_WALK:  if (walkDone) state <= ST_IDLE;
        ST_SWEEP: begin
          if (sweepEnd) state <= ST_IDLE;
          else sweepIdx <= sweepIdx + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspPa    <= '0;
      rspFault <= 1'b0;
    end else begin
      rspValid <= 1'b0;
      if (strobe.captureVa && hitAny) begin
        rspValid <= 1'b1;
        rspPa    <= {hitPpn, lkVa[PAGE_SHIFT-1:0]};
        rspFault <= 1'b0;
      end else if (walkReq && walkDone) begin
        rspValid <= 1'b1;
        rspPa    <= walkFault ? '0 : {walkPpn, curVa[PAGE_SHIFT-1:0]};
        rspFault <= walkFault;
      end
    end
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_cache_pkg::*;
#(
  parameter int TLB_ENTRIES = 8,
  parameter int DIR_ENTRIES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regSel,
  input  logic        regWrite,
  input  logic [7:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        lkValid,
  input  logic [31:0] lkVa,
  output logic        lkReady,
  output logic        rspValid,
  output logic [31:0] rspPa,
  output logic        rspFault,
  output logic        walkReq,
  output logic [31:0] walkVa,
  output logic        walkDirHit,
  output logic [31:0] walkDirEntry,
  input  logic        walkDone,
  input  logic        walkFault,
  input  logic [19:0] walkPpn,
  input  logic        walkDirFill,
  input  logic [31:0] walkDirData
);
  localparam int SWEEP_LEN = (TLB_ENTRIES > DIR_ENTRIES) ? TLB_ENTRIES : DIR_ENTRIES;
  localparam int SWW       = (SWEEP_LEN > 1) ? $clog2(SWEEP_LEN) : 1;

  dpStrobe_t        strobe;
  logic [SWW-1:0]   sweepIdx;
  logic             hitAny, maintPending;
  logic [VPN_W-1:0] hitPpn;
  logic [VA_W-1:0]  curVa, invAddr, invMask;
  logic [TAG_W-1:0] walkInvTag;

  xlat_cache_ctrl #(.SWEEP_LEN(SWEEP_LEN), .SWW(SWW)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regSel(regSel), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata),
    .lkValid(lkValid), .lkVa(lkVa), .lkReady(lkReady),
    .hitAny(hitAny), .hitPpn(hitPpn), .curVa(curVa),
    .walkDone(walkDone), .walkFault(walkFault), .walkPpn(walkPpn),
    .walkDirFill(walkDirFill), .walkReq(walkReq),
    .rspValid(rspValid), .rspPa(rspPa), .rspFault(rspFault),
    .strobe(strobe), .sweepIdx(sweepIdx),
    .invAddr(invAddr), .invMask(invMask), .walkInvTag(walkInvTag),
    .maintPending(maintPending)
  );

  xlat_cache_dp #(.TLB_ENTRIES(TLB_ENTRIES), .DIR_ENTRIES(DIR_ENTRIES), .SWW(SWW)) u_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .sweepIdx(sweepIdx),
    .lkVa(lkVa), .walkPpn(walkPpn), .walkDirData(walkDirData),
    .invAddr(invAddr), .invMask(invMask), .walkInvTag(walkInvTag),
    .hitAny(hitAny), .hitPpn(hitPpn),
    .dirHit(walkDirHit), .dirEntry(walkDirEntry), .curVa(curVa)
  );

  assign walkVa = curVa;
endmodule

// File: rtl/xlat_cache_checker.sv
module xlat_cache_checker #(
  parameter int TLB_ENTRIES = 8,
  parameter int DIR_ENTRIES = 4
) (
  input logic clk,
  input logic rstN,
  input logic regSel,
  input logic regWrite,
  input logic lkValid,
  input logic lkReady,
  input logic walkReq,
  input logic walkDone,
  input logic rspValid,
  input logic maintPending
);
  localparam int SWEEP_LEN = (TLB_ENTRIES > DIR_ENTRIES) ? TLB_ENTRIES : DIR_ENTRIES;

  logic [15:0] pendCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendCnt <= '0;
    else if (!maintPending || walkReq || (regSel && regWrite)) pendCnt <= '0;
    else if (pendCnt != 16'hFFFF) pendCnt <= pendCnt + 1'b1;
  end

  assert_stall_pending_R10: assert property (@(posedge clk) disable iff (!rstN)
    maintPending |-> !lkReady);

  assert_rsp_source_R2: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past((lkValid && lkReady) || (walkReq && walkDone)));

  assert_walk_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (walkReq && !walkDone) |=> walkReq);

  assert_walk_blocks_lookup_R3: assert property (@(posedge clk) disable iff (!rstN)
    walkReq |-> !lkReady);

  assert_maint_bound_R11: assert property (@(posedge clk) disable iff (!rstN)
    pendCnt <= 16'(SWEEP_LEN + 2));
endmodule

bind xlat_cache xlat_cache_checker #(.TLB_ENTRIES(TLB_ENTRIES), .DIR_ENTRIES(DIR_ENTRIES)) u_chk (
  .clk(clk), .rstN(rstN), .regSel(regSel), .regWrite(regWrite),
  .lkValid(lkValid), .lkReady(lkReady), .walkReq(walkReq), .walkDone(walkDone),
  .rspValid(rspValid), .maintPending(maintPending)
);

// File: tb/test_xlat_cache.sv
module test_xlat_cache;
  localparam int TLB_N = 8;
  localparam int DIR_N = 4;
  localparam int SWEEP = 8;
  localparam int LIM   = SWEEP + 4;
  localparam logic [7:0] A_FLUSH = 8'h00, A_INVA = 8'h04, A_INVM = 8'h08,
                         A_INVGO = 8'h0C, A_WINVA = 8'h10, A_WINVGO = 8'h14;

  logic clk = 1'b0, rstN = 1'b0;
  logic regSel = 0, regWrite = 0;
  logic [7:0] regAddr = 0;
  logic [31:0] regWdata = 0, regRdata;
  logic lkValid = 0, lkReady, rspValid, rspFault, walkReq, walkDirHit;
  logic [31:0] lkVa = 0, rspPa, walkVa, walkDirEntry, walkDirData = 0;
  logic walkDone = 0, walkFault = 0, walkDirFill = 0;
  logic [19:0] walkPpn = 0;

  always #10 clk = ~clk;

  xlat_cache #(.TLB_ENTRIES(TLB_N), .DIR_ENTRIES(DIR_N)) i_xlat_cache (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .lkValid(lkValid), .lkVa(lkVa),
    .lkReady(lkReady), .rspValid(rspValid), .rspPa(rspPa), .rspFault(rspFault),
    .walkReq(walkReq), .walkVa(walkVa), .walkDirHit(walkDirHit),
    .walkDirEntry(walkDirEntry), .walkDone(walkDone), .walkFault(walkFault),
    .walkPpn(walkPpn), .walkDirFill(walkDirFill), .walkDirData(walkDirData)
  );

  int checks = 0, fails = 0;
  bit mVld [TLB_N];
  logic [19:0] mVpn [TLB_N];
  logic [19:0] mPpn [TLB_N];
  int mRr = 0;
  bit dVld [DIR_N];
  logic [11:0] dTag [DIR_N];
  logic [31:0] dDat [DIR_N];
  int dRr = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] ppnOf(input logic [19:0] vpn);
    return vpn ^ 20'h5A5A5;
  endfunction
  function automatic bit faultOf(input logic [19:0] vpn);
    return vpn[7:0] == 8'h0D;
  endfunction
  function automatic logic [31:0] dteOf(input logic [11:0] tag);
    return {tag, 20'h00C01};
  endfunction
  function automatic int tlbFind(input logic [19:0] vpn);
    for (int i = 0; i < TLB_N; i++) if (mVld[i] && mVpn[i] == vpn) return i;
    return -1;
  endfunction
  function automatic int dirFind(input logic [11:0] tag);
    for (int i = 0; i < DIR_N; i++) if (dVld[i] && dTag[i] == tag) return i;
    return -1;
  endfunction

  task automatic modelInv(input logic [31:0] a, input logic [31:0] m);
    for (int i = 0; i < TLB_N; i++)
      if (mVld[i] && ((({mVpn[i], 12'h000}) ^ a) & m) == 32'd0) mVld[i] = 0;
  endtask
  task automatic modelDirInv(input logic [31:0] a);
    for (int i = 0; i < DIR_N; i++) if (dVld[i] && dTag[i] == a[31:20]) dVld[i] = 0;
  endtask
  task automatic modelFlush(input bit mainC, input bit walkC);
    for (int i = 0; i < TLB_N; i++) if (mainC) mVld[i] = 0;
    for (int i = 0; i < DIR_N; i++) if (walkC) dVld[i] = 0;
  endtask

  task automatic regWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regSel = 1; regWrite = 1; regAddr = a; regWdata = d;
    @(negedge clk);
    regSel = 0; regWrite = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    regSel = 1; regWrite = 0; regAddr = a;
    #1 d = regRdata;
    regSel = 0;
  endtask

  // start an operation, check readback, then poll for completion
  task automatic maint(input logic [7:0] a, input logic [31:0] d, input string req);
    logic [31:0] v;
    int n;
    regWr(a, d);
    rd(a, v);
    chk(v == d, {req, " go bits read back while pending"}, v, d);
    n = 0;
    while ((v & d) != 0 && n < LIM) begin
      @(negedge clk);
      rd(a, v);
      n++;
    end
    chk((v & d) == 0 && n <= SWEEP + 2, {req, " R11 bits clear in bound"}, v, 32'd0);
  endtask

  task automatic doLookup(input logic [31:0] va, input string req);
    int h, dh;
    bit flt;
    logic [19:0] vpn;
    vpn = va[31:12];
    h = tlbFind(vpn);
    @(negedge clk);
    lkValid = 1; lkVa = va;
    #1;
    while (!lkReady) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    lkValid = 0;
    if (h >= 0) begin
      chk(rspValid === 1'b1 && walkReq === 1'b0, {req, " R2 hit answers without walk"},
          {30'd0, rspValid, walkReq}, 32'd2);
      chk(rspPa === {mPpn[h], va[11:0]} && rspFault === 1'b0, {req, " R2 hit address"},
          rspPa, {mPpn[h], va[11:0]});
    end else begin
      chk(walkReq === 1'b1 && walkVa === va && rspValid === 1'b0, {req, " R3 walk request"},
          walkVa, va);
      dh = dirFind(va[31:20]);
      chk(walkDirHit === (dh >= 0), {req, " R8 directory hit flag"},
          {31'd0, walkDirHit}, {31'd0, dh >= 0});
      if (dh >= 0)
        chk(walkDirEntry === dDat[dh], {req, " R8 directory entry"}, walkDirEntry, dDat[dh]);
      flt = faultOf(vpn);
      walkDone = 1; walkFault = flt; walkPpn = ppnOf(vpn);
      walkDirFill = 1; walkDirData = dteOf(va[31:20]);
      @(negedge clk);
      walkDone = 0; walkDirFill = 0;
      chk(rspValid === 1'b1 && rspFault === flt && walkReq === 1'b0,
          {req, flt ? " R4 fault response" : " R3 walk response"},
          {30'd0, rspValid, rspFault}, {30'd0, 1'b1, flt});
      if (!flt) begin
        chk(rspPa === {ppnOf(vpn), va[11:0]}, {req, " R3 walked address"},
            rspPa, {ppnOf(vpn), va[11:0]});
        mVld[mRr] = 1; mVpn[mRr] = vpn; mPpn[mRr] = ppnOf(vpn);
        mRr = (mRr + 1) % TLB_N;
        if (dh < 0) begin
          dVld[dRr] = 1; dTag[dRr] = va[31:20]; dDat[dRr] = dteOf(va[31:20]);
          dRr = (dRr + 1) % DIR_N;
        end
      end
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240));
    for (int i = 0; i < TLB_N; i++) mVld[i] = 0;
    for (int i = 0; i < DIR_N; i++) dVld[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    rd(A_FLUSH, v);  chk(v == 0, "R1 flush bits after reset", v, 0);
    rd(A_INVGO, v);  chk(v == 0, "R1 invalidate go after reset", v, 0);
    rd(A_WINVGO, v); chk(v == 0, "R1 walk invalidate go after reset", v, 0);
    rd(A_INVM, v);   chk(v == 32'hFFFFF000, "R1 mask reset value", v, 32'hFFFFF000);
    chk(lkReady === 1'b1, "R1 ready after reset", {31'd0, lkReady}, 1);
    doLookup(32'h0010_5123, "R1 first lookup");
    doLookup(32'h0010_5FFC, "R2 repeat");
    doLookup(32'h0020_D004, "R4 first");
    doLookup(32'h0020_D008, "R4 not cached");
    doLookup(32'h0010_7000, "R8 same region");

    // R5 round robin wrap
    maint(A_FLUSH, 32'h0003_0000, "R7 full flush");
    modelFlush(1, 1);
    for (int k = 0; k <= TLB_N; k++) doLookup({12'h002, 8'(k), 12'h010}, "R5 fill");
    doLookup(32'h0020_2010, "R5 survivor");
    doLookup(32'h0020_0010, "R5 evicted");

    // R7 all flush bits
    maint(A_FLUSH, 32'h0003_003F, "R7 all bits");
    modelFlush(1, 1);
    doLookup(32'h0020_3010, "R7 after flush");

    // R6 exact and region masks
    doLookup(32'h0030_1000, "R6 fill");
    doLookup(32'h0030_2000, "R6 fill");
    doLookup(32'h0030_5000, "R6 fill");
    regWr(A_INVA, 32'h0030_2ABC);
    regWr(A_INVM, 32'hFFFF_F000);
    maint(A_INVGO, 32'd1, "R6 exact page");
    modelInv(32'h0030_2ABC, 32'hFFFF_F000);
    doLookup(32'h0030_2000, "R6 removed");
    doLookup(32'h0030_1000, "R6 kept");
    regWr(A_INVA, 32'h0030_0000);
    regWr(A_INVM, 32'hFFF0_0000);
    maint(A_INVGO, 32'd1, "R6 region");
    modelInv(32'h0030_0000, 32'hFFF0_0000);
    doLookup(32'h0030_5000, "R6 region removed");

    // R9 directory invalidation
    doLookup(32'h0040_1000, "R9 fill");
    regWr(A_WINVA, 32'h0045_5555);
    maint(A_WINVGO, 32'd1, "R9 walk invalidate");
    modelDirInv(32'h0045_5555);
    doLookup(32'h0040_2000, "R9 region dropped");

    // R10 stall during sweep
    doLookup(32'h0050_1000, "R10 fill");
    regWr(A_INVA, 32'h0050_1000);
    regWr(A_INVM, 32'hFFFF_F000);
    regWr(A_INVGO, 32'd1);
    lkValid = 1; lkVa = 32'h0050_1000;
    #1 chk(lkReady === 1'b0, "R10 lookup held while pending", {31'd0, lkReady}, 0);
    modelInv(32'h0050_1000, 32'hFFFF_F000);
    doLookup(32'h0050_1000, "R10 no stale hit");

    // R11 zero write does nothing
    doLookup(32'h0060_1000, "R11 fill");
    regWr(A_INVA, 32'h0060_1000);
    regWr(A_INVGO, 32'd0);
    rd(A_INVGO, v); chk(v == 0, "R11 zero write not started", v, 0);
    doLookup(32'h0060_1000, "R11 entry kept");

    // constrained random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      logic [31:0] a, m;
      logic [11:0] reg12;
      logic [7:0] lo;
      op = $urandom % 12;
      reg12 = 12'(($urandom % 3) + 1);
      lo = 8'($urandom % 20);
      a = {reg12, lo, 12'($urandom)};
      if (op == 0) begin
        case ($urandom % 3)
          0: m = 32'hFFFF_F000;
          1: m = 32'hFFFF_C000;
          default: m = 32'hFFF0_0000;
        endcase
        regWr(A_INVA, a);
        regWr(A_INVM, m);
        maint(A_INVGO, 32'd1, "R6 random");
        modelInv(a, m);
      end else if (op == 1) begin
        regWr(A_WINVA, a);
        maint(A_WINVGO, 32'd1, "R9 random");
        modelDirInv(a);
      end else if (op == 2) begin
        m = {14'd0, 1'($urandom), 1'($urandom), 10'd0, 6'($urandom)};
        if (m == 0) m = 32'd1;
        maint(A_FLUSH, m, "R7 random");
        modelFlush(m[16], m[17]);
      end else begin
        doLookup(a, "random");
      end
    end
    summary();
  end
endmodule